// File: doc/BRIEF.md
# SMT Commit Thread Selector

This block decides which hardware thread may retire the instruction at the head of its reorder buffer next. For every thread it receives an active flag, a commit status code, a buffer-empty flag, a head-ready flag and the sequence number of the head instruction. From these it reports whether some thread may commit and, if so, which one.

A static policy input picks one of three arbitration modes:
- **Aggressive** picks the qualifying thread whose head carries the smallest sequence number. It may be queried several times within one cycle.
- **Oldest-ready** uses the same selection as aggressive.
- **Round-robin** keeps a rotating priority list. A thread whose selection is accepted moves to the back of that list.

The result is combinational, so the commit stage can query it repeatedly within one cycle. Only the round-robin list holds state. When the block is built for a single thread, the policy is bypassed entirely.

Top module: `commit_thread_sel`

## Requirements
- R1: The status code is 3 bits wide: idle=0, running=1, rob_squashing=2, trap_pending=3, fetch_trap_pending=4. Only codes 0, 1 and 4 make a thread eligible.
- R2: With more than one thread, a thread qualifies when all of these hold: it is active, its buffer is not empty, its head is ready, and its status is eligible.
- R3: When no thread qualifies, `sel_valid_o` is 0.
- R4: The policy encoding is 0=aggressive, 1=round-robin, 2=oldest-ready. Code 3 behaves as oldest-ready.
- R5: In oldest-ready mode, the qualifying thread with the smallest head sequence number is selected. Equal sequence numbers go to the lowest thread index.
- R6: Aggressive mode selects exactly as oldest-ready does, and its outputs hold no state.
- R7: In round-robin mode, the first qualifying thread in list order is selected.
- R8: After reset, the round-robin list is in ascending thread-index order, with thread 0 at the front.
- R9: In round-robin mode, a clock edge with `accept_i`=1 and `sel_valid_o`=1 moves the selected thread to the back of the list. The other threads keep their relative order.
- R10: The list stays unchanged on any edge where `accept_i`=0, where `sel_valid_o`=0, or where the policy is not round-robin.
- R11: With one thread configured, `sel_valid_o` equals "status eligible" and `sel_tid_o` is 0, whatever the policy and the other per-thread inputs.
- R12: The outputs respond combinationally to the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| policy_i | input | 2 | Arbitration policy select |
| active_i | input | N_THR | Per-thread active flag |
| status_i | input | 3*N_THR | Per-thread commit status, thread i in bits [3i+2:3i] |
| empty_i | input | N_THR | Per-thread reorder buffer empty |
| head_rdy_i | input | N_THR | Per-thread head ready to commit |
| head_seq_i | input | SEQ_W*N_THR | Per-thread head sequence number, thread i in slice i |
| accept_i | input | 1 | Current selection is consumed this cycle |
| sel_valid_o | output | 1 | A thread is selected |
| sel_tid_o | output | TID_W | Selected thread index |

## Verification
Selection results are due in the same cycle as the inputs that cause them. The bench therefore drives each input set just after a falling edge and compares the outputs a quarter period later, before the next rising edge. The list rotation of R9 takes effect one rising edge after the accepting cycle. The reference model applies that rotation at the rising edge and compares the effect on the following cycle's selection. A second, single-thread instance covers the bypass of R11.

// File: rtl/cts_pkg.sv
package cts_pkg;
  localparam int unsigned ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE      = 3'd0,
    ST_RUNNING   = 3'd1,
    ST_ROB_SQ    = 3'd2,
    ST_TRAP_PEND = 3'd3,
    ST_FTRAP     = 3'd4
  } cmt_status_e;

  typedef enum logic [1:0] {
    POL_AGGR   = 2'd0,
    POL_RR     = 2'd1,
    POL_OLDEST = 2'd2
  } cmt_policy_e;

  function automatic logic st_eligible(logic [ST_W-1:0] s);
    return (s == ST_IDLE) || (s == ST_RUNNING) || (s == ST_FTRAP);
  endfunction
endpackage

// File: rtl/cts_qualify.sv
module cts_qualify
  import cts_pkg::*;
#(
  parameter int unsigned N_THR = 4
) (
  input  logic [N_THR-1:0]      active_i,
  input  logic [N_THR*ST_W-1:0] status_i,
  input  logic [N_THR-1:0]      empty_i,
  input  logic [N_THR-1:0]      head_rdy_i,
  output logic [N_THR-1:0]      elig_o,
  output logic [N_THR-1:0]      qual_o
);
  for (genvar i = 0; i < N_THR; i++) begin : g_thr
    assign elig_o[i] = st_eligible(status_i[i*ST_W +: ST_W]);
    assign qual_o[i] = elig_o[i] & active_i[i] & ~empty_i[i] & head_rdy_i[i];
  end
endmodule

// File: rtl/cts_oldest.sv
module cts_oldest #(
  parameter int unsigned N_THR = 4,
  parameter int unsigned SEQ_W = 16,
  localparam int unsigned TID_W = (N_THR > 1) ? $clog2(N_THR) : 1
) (
  input  logic [N_THR-1:0]       qual_i,
  input  logic [N_THR*SEQ_W-1:0] seq_i,
  output logic                   hit_o,
  output logic [TID_W-1:0]       tid_o
);
  logic [SEQ_W-1:0] best_seq;

  // strict compare keeps the lowest index on ties
  always_comb begin
    hit_o    = 1'b0;
    tid_o    = '0;
    best_seq = '0;
    for (int i = 0; i < N_THR; i++) begin
      if (qual_i[i] && (!hit_o || seq_i[i*SEQ_W +: SEQ_W] < best_seq)) begin
        hit_o    = 1'b1;
        tid_o    = TID_W'(i);
        best_seq = seq_i[i*SEQ_W +: SEQ_W];
      end
    end
  end
endmodule

// File: rtl/cts_rr_order.sv
module cts_rr_order #(
  parameter int unsigned N_THR = 4,
  localparam int unsigned TID_W = (N_THR > 1) ? $clog2(N_THR) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_THR-1:0]  qual_i,
  input  logic              upd_i,
  output logic              hit_o,
  output logic [TID_W-1:0]  tid_o
);
  logic [TID_W-1:0] ord_q [N_THR];
  logic [TID_W-1:0] pos;

  always_comb begin
    hit_o = 1'b0;
    tid_o = '0;
    pos   = '0;
    for (int i = 0; i < N_THR; i++) begin
      if (!hit_o && qual_i[ord_q[i]]) begin
        hit_o = 1'b1;
        tid_o = ord_q[i];
        pos   = TID_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_THR; i++) ord_q[i] <= TID_W'(i);
    end else if (upd_i && hit_o) begin
      for (int i = 0; i < N_THR - 1; i++)
        if (TID_W'(i) >= pos) ord_q[i] <= ord_q[i+1];
      ord_q[N_THR-1] <= tid_o;
    end
  end
endmodule

// File: rtl/commit_thread_sel.sv
module commit_thread_sel
  import cts_pkg::*;
#(
  parameter int unsigned N_THR = 4,
  parameter int unsigned SEQ_W = 16,
  localparam int unsigned TID_W = (N_THR > 1) ? $clog2(N_THR) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             policy_i,
  input  logic [N_THR-1:0]       active_i,
  input  logic [N_THR*ST_W-1:0]  status_i,
  input  logic [N_THR-1:0]       empty_i,
  input  logic [N_THR-1:0]       head_rdy_i,
  input  logic [N_THR*SEQ_W-1:0] head_seq_i,
  input  logic                   accept_i,
  output logic                   sel_valid_o,
  output logic [TID_W-1:0]       sel_tid_o
);
  logic [N_THR-1:0] elig, qual;

  cts_qualify #(.N_THR(N_THR)) u_qual (
    .active_i(active_i), .status_i(status_i), .empty_i(empty_i),
    .head_rdy_i(head_rdy_i), .elig_o(elig), .qual_o(qual)
  );

  if (N_THR == 1) begin : g_single
    logic unused_ok;
    assign unused_ok   = ^{clk_i, rst_ni, policy_i, qual, head_seq_i, accept_i};
    assign sel_valid_o = elig[0];
    assign sel_tid_o   = '0;
  end else begin : g_multi
    logic             rr_hit, old_hit, is_rr;
    logic [TID_W-1:0] rr_tid, old_tid;

    assign is_rr = (policy_i == POL_RR);

    cts_rr_order #(.N_THR(N_THR)) u_rr (
      .clk_i(clk_i), .rst_ni(rst_ni), .qual_i(qual),
      .upd_i(accept_i & is_rr), .hit_o(rr_hit), .tid_o(rr_tid)
    );

    cts_oldest #(.N_THR(N_THR), .SEQ_W(SEQ_W)) u_old (
      .qual_i(qual), .seq_i(head_seq_i), .hit_o(old_hit), .tid_o(old_tid)
    );

    assign sel_valid_o = is_rr ? rr_hit : old_hit;
    assign sel_tid_o   = is_rr ? rr_tid : old_tid;
  end
endmodule

// File: rtl/commit_thread_sel_chk.sv
module commit_thread_sel_chk
  import cts_pkg::*;
#(
  parameter int unsigned N_THR = 4,
  parameter int unsigned SEQ_W = 16,
  localparam int unsigned TID_W = (N_THR > 1) ? $clog2(N_THR) : 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [1:0]             policy_i,
  input logic [N_THR-1:0]       active_i,
  input logic [N_THR*ST_W-1:0]  status_i,
  input logic [N_THR-1:0]       empty_i,
  input logic [N_THR-1:0]       head_rdy_i,
  input logic [N_THR*SEQ_W-1:0] head_seq_i,
  input logic                   accept_i,
  input logic                   sel_valid_o,
  input logic [TID_W-1:0]       sel_tid_o
);
  logic [N_THR-1:0] q;
  logic             older_exists;

  always_comb begin
    older_exists = 1'b0;
    for (int i = 0; i < N_THR; i++) begin
      if (N_THR == 1) q[i] = st_eligible(status_i[i*ST_W +: ST_W]);
      else q[i] = active_i[i] & ~empty_i[i] & head_rdy_i[i] &
                  st_eligible(status_i[i*ST_W +: ST_W]);
      if (q[i] && head_seq_i[i*SEQ_W +: SEQ_W] <
          head_seq_i[int'(sel_tid_o)*SEQ_W +: SEQ_W]) older_exists = 1'b1;
    end
  end

  // R12
  tid_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> int'(sel_tid_o) < N_THR);

  // R2
  sel_qualifies_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> q[sel_tid_o]);

  // R3
  none_no_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q == '0) |-> !sel_valid_o);

  // R5
  oldest_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_valid_o && policy_i != 2'd1 && N_THR > 1) |-> !older_exists);

  logic unused_ok;
  assign unused_ok = accept_i;
endmodule

bind commit_thread_sel commit_thread_sel_chk #(.N_THR(N_THR), .SEQ_W(SEQ_W)) u_chk (.*);

// File: tb/commit_thread_sel_tb.sv
module commit_thread_sel_tb;
  localparam int N = 4;
  localparam int SW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] pol = 2'd0;
  logic [N-1:0] act = '0, emp = '1, rdy = '0;
  logic [N*3-1:0] st = '0;
  logic [N*SW-1:0] seq = '0;
  logic acc = 1'b0;
  logic vld;
  logic [1:0] tid;

  logic [1:0] pol1 = 2'd0;
  logic [2:0] st1 = 3'd0;
  logic act1 = 1'b0, emp1 = 1'b1, rdy1 = 1'b0;
  logic [SW-1:0] seq1 = '0;
  logic vld1;
  logic tid1;

  int checks = 0, errors = 0;
  int q[$];

  always #10 clk = ~clk;

  commit_thread_sel #(.N_THR(N), .SEQ_W(SW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(pol), .active_i(act), .status_i(st),
    .empty_i(emp), .head_rdy_i(rdy), .head_seq_i(seq), .accept_i(acc),
    .sel_valid_o(vld), .sel_tid_o(tid));

  commit_thread_sel #(.N_THR(1), .SEQ_W(SW)) u_one (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(pol1), .active_i(act1), .status_i(st1),
    .empty_i(emp1), .head_rdy_i(rdy1), .head_seq_i(seq1), .accept_i(1'b0),
    .sel_valid_o(vld1), .sel_tid_o(tid1));

  function automatic bit elig(int s);
    return s == 0 || s == 1 || s == 4;
  endfunction

  function automatic bit qualf(int i);
    return act[i] && !emp[i] && rdy[i] && elig(int'(st[i*3 +: 3]));
  endfunction

  // model selection (R1 R2 R4 R5 R6 R7)
  task automatic ref_pick(output bit v, output int t);
    v = 0; t = 0;
    if (pol == 2'd1) begin
      foreach (q[k]) if (!v && qualf(q[k])) begin v = 1; t = q[k]; end
    end else begin
      for (int i = 0; i < N; i++)
        if (qualf(i) && (!v || seq[i*SW +: SW] < seq[t*SW +: SW])) begin v = 1; t = i; end
    end
  endtask

  task automatic check(string req, bit ev, int et);
    checks++;
    if (vld !== ev || (ev && int'(tid) != et)) begin
      errors++;
      $display("FAIL %s: got valid=%0b tid=%0d expected valid=%0b tid=%0d", req, vld, tid, ev, et);
    end
  endtask

  // one cycle: drive after negedge, check mid-low, model update at posedge (R9 R10)
  task automatic cycle(string req);
    bit ev; int et;
    #5;
    ref_pick(ev, et);
    check(req, ev, et);
    @(posedge clk);
    if (acc && ev && pol == 2'd1) begin
      foreach (q[k]) if (q[k] == et) begin q.delete(k); break; end
      q.push_back(et);
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    q = {};
    for (int i = 0; i < N; i++) q.push_back(i);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic randomize_in(bit tie);
    for (int i = 0; i < N; i++) begin
      act[i] = ($urandom_range(0, 7) != 0);
      emp[i] = ($urandom_range(0, 5) == 0);
      rdy[i] = ($urandom_range(0, 3) != 0);
      st[i*3 +: 3] = 3'($urandom_range(0, 4));
      seq[i*SW +: SW] = tie ? SW'($urandom_range(0, 3)) : SW'($urandom);
    end
    acc = $urandom_range(0, 1);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R3 reset state: nothing qualifies
    cycle("R3");

    // R1 status gating: all ready, only thread 2 squashing-free
    act = '1; emp = '0; rdy = '1; pol = 2'd2;
    st = {3'd3, 3'd1, 3'd2, 3'd2};
    seq = {16'd1, 16'd9, 16'd0, 16'd0};
    cycle("R1");
    st = {3'd4, 3'd3, 3'd2, 3'd3};
    cycle("R1");

    // R5 ties to lowest index
    st = '0; seq = {16'd5, 16'd3, 16'd3, 16'd7};
    cycle("R5");
    // R6 aggressive equals oldest; R4 code 3
    pol = 2'd0; cycle("R6");
    pol = 2'd3; cycle("R4");

    // R2 empty / not active / not ready
    pol = 2'd2; emp = 4'b0010; act = 4'b1011; rdy = 4'b0111; seq = {16'd0, 16'd1, 16'd2, 16'd3};
    cycle("R2");

    // R8 R7 R9 round-robin from reset
    do_reset();
    pol = 2'd1; act = '1; emp = '0; rdy = '1; st = '0; acc = 1'b1;
    for (int k = 0; k < 6; k++) cycle("R9");
    // R10 no accept keeps order
    acc = 1'b0; for (int k = 0; k < 3; k++) cycle("R10");
    do_reset();
    pol = 2'd1; rdy = 4'b1100; acc = 1'b0; cycle("R8");
    acc = 1'b1; cycle("R9"); rdy = '1; cycle("R7");

    // random sweeps per policy (R12 same-cycle response)
    for (int p = 0; p < 4; p++) begin
      pol = 2'(p);
      for (int k = 0; k < 300; k++) begin
        randomize_in(k[0]);
        cycle("R12");
      end
    end
    // policy switches mid-run with accepts (R10)
    for (int k = 0; k < 300; k++) begin
      randomize_in(1'b1);
      pol = 2'($urandom_range(0, 2));
      cycle("R10");
    end

    // R11 single-thread bypass
    for (int s = 0; s < 5; s++) begin
      st1 = 3'(s); pol1 = 2'(s % 3); act1 = s[0]; emp1 = s[1]; rdy1 = s[0]; seq1 = SW'(s);
      #5;
      checks++;
      if (vld1 !== elig(s) || tid1 !== 1'b0) begin
        errors++;
        $display("FAIL R11: got valid=%0b tid=%0b expected valid=%0b tid=0", vld1, tid1, elig(s));
      end
      @(negedge clk);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule